// File: doc/BRIEF.md
# Top-Four Rank Selector

This block picks, for every bunch crossing, the four best of 36 candidate words. The candidates come from twelve sources with three candidates each. Each candidate word carries a 7-bit rank in its low bits and a payload above that. The block runs on the fast clock, which ticks twice per crossing. Each source sends its three candidates as two halves on consecutive fast cycles. The block first puts the halves back together into full words, then finds the winners in a fixed pipeline with no stall. A new crossing may start every second cycle.

The four output ports are ordered best first. Each port carries the winning word unchanged, together with the index of its source and the index of its slot within that source. When ranks are equal, the lower source wins, and within one source the lower slot wins. A zero rank means an empty candidate. A port whose winner would be empty outputs zeros.

Top module: `top4_rank_sorter`

## Requirements
- R1: While reset is active and after it is released, `out_valid` is low and the winner outputs (`win_data`, `win_src`, `win_slot`) are all zero until the first crossing is reported.
- R2: The crossing's first half is presented in a cycle with `in_first` high and its second half in the following cycle. For source s, the 48-bit word {second half, first half} is taken from bits [s*24 +: 24] of `in_data`. Slot k occupies bits [k*16 +: 16] of that word.
- R3: The result of a crossing appears on the outputs, with `out_valid` high, exactly 7 rising edges after the edge that samples its first half. That edge counts as the first.
- R4: The rank of a candidate is bits [6:0] of its 16-bit word. The four ports report the four highest-ranked nonzero candidates of the crossing.
- R5: Port 0 holds the highest rank. Ranks never increase from port k to port k+1.
- R6: Among equal ranks, a candidate with a lower index src*3+slot is placed ahead of one with a higher index.
- R7: A zero-rank candidate never wins over a nonzero one. When fewer than four candidates are nonzero, the unused ports output zero in data, source and slot.
- R8: Port k packs its fields as follows: `win_src[k*4 +: 4]` holds the source index, `win_slot[k*2 +: 2]` holds the slot index (0 to 2), and `win_data[k*16 +: 16]` holds the unchanged candidate word.
- R9: `in_first` may be asserted every second cycle. Each crossing then produces exactly one single-cycle `out_valid` pulse, and no result is dropped or merged with another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, two cycles per crossing |
| rst_n | input | 1 | Active-low synchronous reset |
| in_first | input | 1 | High in the cycle carrying the first half of a crossing |
| in_data | input | 288 | Half-words of all twelve sources, 24 bits each |
| out_valid | output | 1 | One-cycle strobe marking a crossing's winners |
| win_data | output | 64 | Four winning candidate words, port 0 best |
| win_src | output | 16 | Source index of each winner |
| win_slot | output | 8 | Slot index of each winner |

## Verification
Every crossing's winners are due on the seventh rising edge after the edge that samples its first half. That is two edges to rebuild the words and five for selection. When the bench sends a crossing, it records the cycle count. A monitor reads the outputs on the falling edge and requires each `out_valid` pulse to land exactly seven cycles after the matching send. Crossings are sent back to back, one every two cycles, so up to four results are in flight at once. The monitor therefore matches each pulse against a queue of sent crossings in order. Any pulse with no crossing pending counts as a miscompare.

// File: rtl/top4_rank_sorter.sv
module top4_rank_sorter #(
  parameter int NSRC        = 12,
  parameter int NSLOT       = 3,
  parameter int CAND_W      = 16,
  parameter int RANK_W      = 7,
  parameter int NWIN        = 4,
  parameter int SORT_STAGES = 5
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_first,
  input  logic [NSRC*NSLOT*CAND_W/2-1:0]      in_data,
  output logic                                out_valid,
  output logic [NWIN*CAND_W-1:0]              win_data,
  output logic [NWIN*$clog2(NSRC)-1:0]        win_src,
  output logic [NWIN*$clog2(NSLOT)-1:0]       win_slot
);
  localparam int NCAND  = NSRC * NSLOT;
  localparam int HALF_W = NSLOT * CAND_W / 2;
  localparam int SRC_W  = $clog2(NSRC);
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int CNT_W  = $clog2(NCAND);
  localparam int WW     = SRC_W + SLOT_W + CAND_W;

  // rebuild full candidate words from the two half transfers
  logic [NSRC*HALF_W-1:0] lo_q;
  logic                   phase_q, cand_vld;
  logic [CAND_W-1:0]      cand_q [NCAND];

  always_ff @(posedge clk)
    if (in_first) lo_q <= in_data;

  always_ff @(posedge clk)
    if (!rst_n) begin
      phase_q  <= 1'b0;
      cand_vld <= 1'b0;
    end else begin
      phase_q  <= in_first;
      cand_vld <= phase_q;
    end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [2*HALF_W-1:0] word;
    assign word = {in_data[s*HALF_W +: HALF_W], lo_q[s*HALF_W +: HALF_W]};
    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      always_ff @(posedge clk)
        if (phase_q) cand_q[s*NSLOT+k] <= word[k*CAND_W +: CAND_W];
    end
  end

  // stage 1: each candidate counts how many others beat it
  logic [CAND_W-1:0] c1   [NCAND];
  logic [CNT_W-1:0]  cnt1 [NCAND];
  logic [CNT_W-1:0]  cnt_c[NCAND];
  logic              v1;

  always_comb
    for (int i = 0; i < NCAND; i++) begin
      cnt_c[i] = '0;
      for (int j = 0; j < NCAND; j++)
        if (j != i &&
            ((cand_q[j][RANK_W-1:0] >  cand_q[i][RANK_W-1:0]) ||
             (cand_q[j][RANK_W-1:0] == cand_q[i][RANK_W-1:0] && j < i)))
          cnt_c[i] = cnt_c[i] + 1'b1;
    end

  always_ff @(posedge clk) begin
    c1   <= cand_q;
    cnt1 <= cnt_c;
  end

  // stage 2: place the candidate with count k on port k, then delay
  logic [NWIN*WW-1:0] w_c;
  logic [NWIN*WW-1:0] pipe [SORT_STAGES-1];
  logic [SORT_STAGES-2:0] vp;

  always_comb begin
    w_c = '0;
    for (int k = 0; k < NWIN; k++)
      for (int i = 0; i < NCAND; i++)
        if (cnt1[i] == CNT_W'(k) && c1[i][RANK_W-1:0] != '0)
          w_c[k*WW +: WW] = w_c[k*WW +: WW] |
                            {SRC_W'(i / NSLOT), SLOT_W'(i % NSLOT), c1[i]};
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      v1 <= 1'b0;
      vp <= '0;
      for (int n = 0; n < SORT_STAGES-1; n++) pipe[n] <= '0;
    end else begin
      v1      <= cand_vld;
      vp      <= {vp[SORT_STAGES-3:0], v1};
      pipe[0] <= w_c;
      for (int n = 1; n < SORT_STAGES-1; n++) pipe[n] <= pipe[n-1];
    end

  assign out_valid = vp[SORT_STAGES-2];

  for (genvar k = 0; k < NWIN; k++) begin : g_out
    assign {win_src[k*SRC_W +: SRC_W], win_slot[k*SLOT_W +: SLOT_W],
            win_data[k*CAND_W +: CAND_W]} = pipe[SORT_STAGES-2][k*WW +: WW];
  end

  // checks
  assert_demux_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cand_vld |-> $past(in_first, 2));

  assert_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(in_first)) |=> !out_valid);

  for (genvar k = 0; k < NWIN-1; k++) begin : g_chk
    logic [RANK_W-1:0] ra, rb;
    assign ra = win_data[k*CAND_W +: RANK_W];
    assign rb = win_data[(k+1)*CAND_W +: RANK_W];

    assert_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ra >= rb);

    assert_empty_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ra == '0) |-> (rb == '0 && win_src[(k+1)*SRC_W +: SRC_W] == '0));

    assert_tie_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ra == rb && ra != '0) |->
      ({win_src[k*SRC_W +: SRC_W], win_slot[k*SLOT_W +: SLOT_W]} <
       {win_src[(k+1)*SRC_W +: SRC_W], win_slot[(k+1)*SLOT_W +: SLOT_W]}));
  end
endmodule

// File: tb/top4_rank_sorter_bench.sv
module top4_rank_sorter_bench;
  localparam int NV = 10;
  localparam int SEEDS [NV] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_first = 1'b0;
  logic [287:0] in_data = '0;
  logic         out_valid;
  logic [63:0]  win_data;
  logic [15:0]  win_src;
  logic [7:0]   win_slot;

  top4_rank_sorter u_top4_rank_sorter (
    .clk(clk), .rst_n(rst_n), .in_first(in_first), .in_data(in_data),
    .out_valid(out_valid), .win_data(win_data), .win_src(win_src), .win_slot(win_slot)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, sent = 0, got = 0;
  int seed_q [32];
  int due_q  [32];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(int seed, int i);
    logic [6:0] r;
    case (seed)
      0: r = 7'd0;
      1: r = 7'd5;
      2: r = (i == 7) ? 7'd9 : (i == 30) ? 7'd100 : 7'd0;
      3: r = (i >= 33) ? 7'd127 : 7'(i);
      4: r = (i % 4 == 0) ? 7'd60 : 7'd3;
      default: r = 7'(((i * 37 + seed * 53) ^ (i >> 1)) % 128);
    endcase
    return {9'((seed * 11 + i * 3) & 9'h1FF), r};
  endfunction

  task automatic send(int seed);
    logic [47:0] w;
    logic [287:0] lo, hi;
    for (int s = 0; s < 12; s++) begin
      w = {mk(seed, s*3+2), mk(seed, s*3+1), mk(seed, s*3)};
      lo[s*24 +: 24] = w[23:0];
      hi[s*24 +: 24] = w[47:24];
    end
    @(negedge clk);
    seed_q[sent] = seed;
    due_q[sent]  = cyc + 7;
    sent++;
    in_first = 1'b1;
    in_data  = lo;
    @(negedge clk);
    in_first = 1'b0;
    in_data  = hi;
  endtask

  // monitor: compare each strobe against an independent pick-the-max model
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (got >= sent) check(0, "R9 unexpected strobe", 1, 0);
      else begin
        bit taken [36];
        int sd;
        sd = seed_q[got];
        foreach (taken[i]) taken[i] = 0;
        check(cyc == due_q[got], "R3 latency", cyc, due_q[got]);
        for (int k = 0; k < 4; k++) begin
          int best;
          logic [15:0] ed;
          logic [3:0] es;
          logic [1:0] el;
          best = -1;
          for (int i = 0; i < 36; i++)
            if (!taken[i] && mk(sd, i)[6:0] != 0 &&
                (best < 0 || mk(sd, i)[6:0] > mk(sd, best)[6:0]))
              best = i;
          if (best < 0) begin
            ed = '0; es = '0; el = '0;
          end else begin
            taken[best] = 1;
            ed = mk(sd, best); es = 4'(best / 3); el = 2'(best % 3);
          end
          check(win_data[k*16 +: 16] == ed, "R4/R5/R6/R7 winner data",
                win_data[k*16 +: 16], ed);
          check(win_src[k*4 +: 4] == es && win_slot[k*2 +: 2] == el,
                "R8/R2 source and slot", {win_src[k*4 +: 4], win_slot[k*2 +: 2]},
                {es, el});
        end
      end
      got++;
    end
  end

  initial begin
    #(200000 * 8);
    check(0, "watchdog", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1 valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 0 && win_data == '0 && win_src == '0 && win_slot == '0,
          "R1 outputs after reset", win_data, 0);
    // table walk, one crossing every two cycles (R9)
    for (int v = 0; v < NV; v++) send(SEEDS[v]);
    repeat (12) @(negedge clk);
    check(got == NV, "R9 one strobe per crossing", got, NV);
    // isolated crossings after idle gaps
    send(2);
    repeat (10) @(negedge clk);
    send(3);
    repeat (10) @(negedge clk);
    check(got == NV + 2, "R3 isolated results", got, NV + 2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule